// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit buses, A and B, and can pass data in either direction. Each direction has its own storage register. The A-to-B register samples the A bus on its own clock. The B-to-A register samples the B bus on a second, unrelated clock. Neither clock is qualified by any control input, so either register can load at any time. This includes times when neither bus is driven and times when a bus is being driven by this block.

A select input for each direction picks what the driven bus carries: the opposite bus as it is right now (a combinational path with no clock delay), or that direction's stored value. An active-low output enable and a direction input choose which bus is driven, if any. The two buses are never driven at the same time.

Tristate pads are modelled as separate input, output and output-enable signals for each bus. A bus output that is not driven reads zero. An asynchronous active-low reset clears both registers, so a stored path gives a defined value after power-up.

Top module: `bus_xcvr_reg`

## Requirements
- R1: On each rising edge of `clk_ab_i`, the A-to-B register loads `a_i`. The load happens whatever the values of `oe_ni`, `dir_i` and the selects.
- R2: On each rising edge of `clk_ba_i`, the B-to-A register loads `b_i`. The load happens whatever the values of `oe_ni`, `dir_i` and the selects.
- R3: While `oe_ni` is 1, `a_oe_o` and `b_oe_o` are both 0 and both `a_o` and `b_o` read zero. Captures made in this state are kept for later use.
- R4: `a_oe_o` and `b_oe_o` are never 1 together, for any mix of `oe_ni`, `dir_i`, `sel_ab_i` and `sel_ba_i`.
- R5: While `oe_ni` is 0, setting `dir_i`=1 drives bus B (`b_oe_o`=1, `a_oe_o`=0). Setting `dir_i`=0 drives bus A (`a_oe_o`=1, `b_oe_o`=0).
- R6: While B is driven, `sel_ab_i`=0 makes `b_o` follow `a_i` in the same cycle. `sel_ab_i`=1 makes `b_o` show the A-to-B register.
- R7: While A is driven, `sel_ba_i`=0 makes `a_o` follow `b_i` in the same cycle. `sel_ba_i`=1 makes `a_o` show the B-to-A register.
- R8: While `rst_ni` is 0, both registers are cleared to zero at once, without waiting for a clock edge.
- R9: While the block drives bus B from A, a `clk_ba_i` edge stores the value on bus B into the B-to-A register. That value can later be sent back onto bus A.
- R10: An edge on one register clock leaves the other register's contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab_i | input | 1 | Capture clock of the A-to-B register |
| clk_ba_i | input | 1 | Capture clock of the B-to-A register |
| rst_ni | input | 1 | Asynchronous active-low reset of both registers |
| oe_ni | input | 1 | Active-low output enable for both buses |
| dir_i | input | 1 | 1: drive B from the A side, 0: drive A from the B side |
| sel_ab_i | input | 1 | Source of B output: 0 live A bus, 1 stored A-to-B value |
| sel_ba_i | input | 1 | Source of A output: 0 live B bus, 1 stored B-to-A value |
| a_i | input | 8 | Value seen on bus A pads |
| a_o | output | 8 | Value driven onto bus A |
| a_oe_o | output | 1 | Pad enable for bus A |
| b_i | input | 8 | Value seen on bus B pads |
| b_o | output | 8 | Value driven onto bus B |
| b_oe_o | output | 1 | Pad enable for bus B |

## Verification
The assertions check the following on every `clk_ab_i` edge:
- the pad enables are never both high;
- both buses are quiet while the enable is off;
- the enable follows `dir_i`;
- each live path equals the opposite input;
- a stored B output equals the A value sampled at the previous edge.

Only the bench's scenarios can show the following:
- the `clk_ba_i` register captures on its own schedule;
- a value captured while its bus was being driven can be returned;
- an edge on one register clock leaves the other register alone;
- reset clears the stored values without a clock edge.

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;

  // which pad group, if any, is enabled
  typedef enum logic [1:0] {
    DRV_NONE = 2'b00,
    DRV_A    = 2'b01,
    DRV_B    = 2'b10
  } drive_e;

  localparam int unsigned PATH_AB = 0;
  localparam int unsigned PATH_BA = 1;
  localparam int unsigned N_PATHS = 2;

endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  // not gated by any control input: loads on every edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end

endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             en_i,
  input  logic             sel_stored_i,
  input  logic [WIDTH-1:0] live_i,
  input  logic [WIDTH-1:0] stored_i,
  output logic [WIDTH-1:0] data_o
);

  always_comb begin
    if (!en_i)             data_o = '0;
    else if (sel_stored_i) data_o = stored_i;
    else                   data_o = live_i;
  end

endmodule

// File: rtl/xcvr_drive_ctrl.sv
module xcvr_drive_ctrl
  import bus_xcvr_pkg::*;
(
  input  logic   oe_ni,
  input  logic   dir_i,
  output drive_e drive_o
);

  always_comb begin
    if (oe_ni)      drive_o = DRV_NONE;
    else if (dir_i) drive_o = DRV_B;
    else            drive_o = DRV_A;
  end

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
  import bus_xcvr_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_ab_i,
  input  logic             clk_ba_i,
  input  logic             rst_ni,
  input  logic             oe_ni,
  input  logic             dir_i,
  input  logic             sel_ab_i,
  input  logic             sel_ba_i,
  input  logic [WIDTH-1:0] a_i,
  output logic [WIDTH-1:0] a_o,
  output logic             a_oe_o,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] b_o,
  output logic             b_oe_o
);

  drive_e drive;

  logic [N_PATHS-1:0] clk_v;
  logic [N_PATHS-1:0] sel_v;
  logic [N_PATHS-1:0] en_v;
  logic [WIDTH-1:0]   src_v  [N_PATHS];
  logic [WIDTH-1:0]   q_v    [N_PATHS];
  logic [WIDTH-1:0]   out_v  [N_PATHS];

  xcvr_drive_ctrl u_drive (
    .oe_ni   (oe_ni),
    .dir_i   (dir_i),
    .drive_o (drive)
  );

  // path index: source bus -> destination bus
  assign clk_v[PATH_AB] = clk_ab_i;
  assign clk_v[PATH_BA] = clk_ba_i;
  assign sel_v[PATH_AB] = sel_ab_i;
  assign sel_v[PATH_BA] = sel_ba_i;
  assign en_v[PATH_AB]  = (drive == DRV_B);
  assign en_v[PATH_BA]  = (drive == DRV_A);
  assign src_v[PATH_AB] = a_i;
  assign src_v[PATH_BA] = b_i;

  for (genvar g = 0; g < N_PATHS; g++) begin : g_path
    xcvr_capture_reg #(.WIDTH(WIDTH)) u_reg (
      .clk_i  (clk_v[g]),
      .rst_ni (rst_ni),
      .d_i    (src_v[g]),
      .q_o    (q_v[g])
    );

    xcvr_path_mux #(.WIDTH(WIDTH)) u_mux (
      .en_i         (en_v[g]),
      .sel_stored_i (sel_v[g]),
      .live_i       (src_v[g]),
      .stored_i     (q_v[g]),
      .data_o       (out_v[g])
    );
  end

  assign b_o    = out_v[PATH_AB];
  assign a_o    = out_v[PATH_BA];
  assign b_oe_o = en_v[PATH_AB];
  assign a_oe_o = en_v[PATH_BA];

endmodule

// File: rtl/bus_xcvr_reg_chk.sv
module bus_xcvr_reg_chk #(
  parameter int unsigned WIDTH = 8
) (
  input logic             clk_ab_i,
  input logic             rst_ni,
  input logic             oe_ni,
  input logic             dir_i,
  input logic             sel_ab_i,
  input logic             sel_ba_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] a_o,
  input logic             a_oe_o,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] b_o,
  input logic             b_oe_o
);

  // R4
  one_driver_chk: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    !(a_oe_o && b_oe_o));

  // R3
  quiet_when_off_chk: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    oe_ni |-> (!a_oe_o && !b_oe_o && a_o == '0 && b_o == '0));

  // R5
  dir_select_chk: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    !oe_ni |-> (b_oe_o == dir_i && a_oe_o == !dir_i));

  // R6
  live_ab_chk: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    (!oe_ni && dir_i && !sel_ab_i) |-> (b_o == a_i));

  // R7
  live_ba_chk: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    (!oe_ni && !dir_i && !sel_ba_i) |-> (a_o == b_i));

  // R1
  stored_ab_chk: assert property (@(posedge clk_ab_i) disable iff (!rst_ni)
    ($past(rst_ni) && !oe_ni && dir_i && sel_ab_i) |-> (b_o == $past(a_i)));

endmodule

bind bus_xcvr_reg bus_xcvr_reg_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/bus_xcvr_reg_bench.sv
module bus_xcvr_reg_bench;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic       oe_n;
    logic       dir;
    logic       sel_ab;
    logic       sel_ba;
    logic [7:0] a;
    logic [7:0] b;
    logic       exp_a_oe;
    logic       exp_b_oe;
  } vec_t;

  localparam vec_t VECS [16] = '{
    '{1'b0, 1'b0, 1'b0, 1'b0, 8'h12, 8'h34, 1'b1, 1'b0},
    '{1'b0, 1'b0, 1'b0, 1'b1, 8'h21, 8'h43, 1'b1, 1'b0},
    '{1'b0, 1'b0, 1'b1, 1'b0, 8'hA5, 8'h5A, 1'b1, 1'b0},
    '{1'b0, 1'b0, 1'b1, 1'b1, 8'hFF, 8'h00, 1'b1, 1'b0},
    '{1'b0, 1'b1, 1'b0, 1'b0, 8'h0F, 8'hF0, 1'b0, 1'b1},
    '{1'b0, 1'b1, 1'b0, 1'b1, 8'h81, 8'h18, 1'b0, 1'b1},
    '{1'b0, 1'b1, 1'b1, 1'b0, 8'h66, 8'h99, 1'b0, 1'b1},
    '{1'b0, 1'b1, 1'b1, 1'b1, 8'hE7, 8'h7E, 1'b0, 1'b1},
    '{1'b1, 1'b0, 1'b0, 1'b0, 8'h01, 8'h80, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b0, 1'b1, 8'h02, 8'h40, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b1, 1'b0, 8'h04, 8'h20, 1'b0, 1'b0},
    '{1'b1, 1'b0, 1'b1, 1'b1, 8'h08, 8'h10, 1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b0, 1'b0, 8'hC0, 8'h03, 1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b0, 1'b1, 8'h30, 8'h0C, 1'b0, 1'b0},
    '{1'b1, 1'b1, 1'b1, 1'b0, 8'hBE, 8'hEF, 1'b0, 1'b0},
    '{1'b0, 1'b1, 1'b1, 1'b0, 8'h55, 8'hAA, 1'b0, 1'b1}
  };

  logic       clk_ab = 1'b0;
  logic       clk_ba = 1'b0;
  logic       rst_n  = 1'b0;
  logic       oe_n   = 1'b0;
  logic       dir    = 1'b1;
  logic       sel_ab = 1'b1;
  logic       sel_ba = 1'b1;
  logic [7:0] a_in   = 8'h00;
  logic [7:0] b_in   = 8'h00;
  logic [7:0] a_out, b_out;
  logic       a_oe, b_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  bus_xcvr_reg u_bus_xcvr_reg (
    .clk_ab_i (clk_ab),
    .clk_ba_i (clk_ba),
    .rst_ni   (rst_n),
    .oe_ni    (oe_n),
    .dir_i    (dir),
    .sel_ab_i (sel_ab),
    .sel_ba_i (sel_ba),
    .a_i      (a_in),
    .a_o      (a_out),
    .a_oe_o   (a_oe),
    .b_i      (b_in),
    .b_o      (b_out),
    .b_oe_o   (b_oe)
  );

  always #(CLK_PERIOD/2) clk_ab = ~clk_ab;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // a single clk_ba pulse, kept clear of clk_ab edges
  task automatic pulse_ba();
    #1 clk_ba = 1'b1;
    #2 clk_ba = 1'b0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] prev_a;
    logic [7:0] ba_val;

    // R8: reset state, stored paths read zero
    #3;
    chk("R8 b_o stored under reset", b_out, 8'h00);
    chk("R5 b_oe under reset", {7'd0, b_oe}, 8'h01);
    dir = 1'b0;
    #1;
    chk("R8 a_o stored under reset", a_out, 8'h00);
    @(negedge clk_ab);
    @(negedge clk_ab);
    rst_n = 1'b1;

    // preload: A-to-B gets C3, B-to-A gets 3C
    a_in = 8'hC3;
    b_in = 8'h3C;
    pulse_ba();
    ba_val = 8'h3C;
    @(negedge clk_ab);
    prev_a = 8'hC3;

    // table walk: R4 R5 R6 R7 R3 R10
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_ab);
      oe_n   = VECS[i].oe_n;
      dir    = VECS[i].dir;
      sel_ab = VECS[i].sel_ab;
      sel_ba = VECS[i].sel_ba;
      a_in   = VECS[i].a;
      b_in   = VECS[i].b;
      #1;
      chk("R5 a_oe", {7'd0, a_oe}, {7'd0, VECS[i].exp_a_oe});
      chk("R5 b_oe", {7'd0, b_oe}, {7'd0, VECS[i].exp_b_oe});
      chk("R4 single driver", {7'd0, a_oe & b_oe}, 8'h00);
      if (VECS[i].exp_b_oe)
        chk("R6 b_o", b_out, VECS[i].sel_ab ? prev_a : VECS[i].a);
      else
        chk("R3 b_o idle", b_out, 8'h00);
      if (VECS[i].exp_a_oe)
        chk("R7 a_o (R10 held)", a_out, VECS[i].sel_ba ? ba_val : VECS[i].b);
      else
        chk("R3 a_o idle", a_out, 8'h00);
      prev_a = VECS[i].a;
    end

    // R6 live path follows mid-cycle change
    @(negedge clk_ab);
    oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b0; a_in = 8'h3D;
    #1 chk("R6 live b_o", b_out, 8'h3D);
    a_in = 8'hD3;
    #1 chk("R6 live b_o follows", b_out, 8'hD3);

    // R3 + R1 + R2: capture while both buses idle
    @(negedge clk_ab);
    oe_n = 1'b1; a_in = 8'h96; b_in = 8'h69;
    pulse_ba();
    chk("R3 no enables", {6'd0, a_oe, b_oe}, 8'h00);
    @(negedge clk_ab);
    oe_n = 1'b0; dir = 1'b1; sel_ab = 1'b1;
    #1 chk("R1 stored while idle", b_out, 8'h96);
    dir = 1'b0; sel_ba = 1'b1; b_in = 8'h00;
    #1 chk("R2 stored while idle", a_out, 8'h69);

    // R9: capture the value this block drives onto B
    @(negedge clk_ab);
    dir = 1'b1; sel_ab = 1'b0; a_in = 8'h5A;
    #1 b_in = b_out;
    pulse_ba();
    dir = 1'b0; sel_ba = 1'b1; b_in = 8'h11;
    #1 chk("R9 returned value", a_out, 8'h5A);

    // R10: clk_ba edge leaves A-to-B register alone
    @(negedge clk_ab);
    a_in = 8'h77;
    @(negedge clk_ab);
    a_in = 8'h88; b_in = 8'h22;
    pulse_ba();
    dir = 1'b1; sel_ab = 1'b1;
    #1 chk("R10 A-to-B held", b_out, 8'h77);

    // R8: asynchronous clear mid-run
    @(negedge clk_ab);
    #2 rst_n = 1'b0;
    #1 chk("R8 async clear AB", b_out, 8'h00);
    dir = 1'b0;
    #1 chk("R8 async clear BA", a_out, 8'h00);
    @(negedge clk_ab);
    @(negedge clk_ab);
    rst_n = 1'b1;
    @(negedge clk_ab);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule